// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a 16-bit count-down watchdog with a small word-addressed register port. Software programs a reload value and a control word, then must keep writing a key value to a refresh register before the count runs out. The count advances on ticks from a four-step prescaler. When the count reaches zero the block either pulses a reset request for the reset controller or, for debugging in active mode, raises a sticky interrupt that software clears through its own register.

A hibernate input can freeze the countdown when the control word allows it. Counting then resumes from the held value once hibernate drops. The timer runs in two modes. In periodic mode it reloads from the programmed value after zero. In free-running mode it wraps to 0x1000 after zero.

Top module: `wdt_top`

## Requirements
- R1: After reset the reload register reads 0x1000, the count reads 0x1000, the control word reads 0x00E9, and both `rstReq` and `irq` are low.
- R2: Control word layout (byte offset 0x08): bit 6 = periodic (1) / free-running (0), bit 5 = enable, bits 3:2 = prescale select, bit 1 = interrupt select, bit 0 = hibernate suspend. Bit 7 always reads 1. Bits 15:8 and bit 4 always read 0 and ignore writes. An unmapped offset reads 0.
- R3: While running, the count drops by one once every 1, 16, 256 or 4096 clocks for prescale select 00, 01, 10 or 11. The divider phase steps once per running clock and produces a tick when it is at or above the limit for the current select, then returns to 0.
- R4: In periodic mode, a tick that finds the count at zero reloads the value held in the reload register (offset 0x00). Any tick whose new count is zero is a timeout.
- R5: In free-running mode, a tick that finds the count at zero loads 0x1000, whatever the reload register holds.
- R6: When interrupt select is 0, a timeout drives `rstReq` high for the single clock that follows the timeout tick.
- R7: When interrupt select is 1 and `active` is high, a timeout sets `irq` and leaves `rstReq` low. `irq` stays high until any write to offset 0x10, and a timeout in the same cycle as that write wins. When `active` is low, the timeout raises `rstReq` instead.
- R8: With hibernate suspend set, the count and divider phase hold while `hibernate` is high, and counting resumes from the held value afterwards. With hibernate suspend clear, counting continues during hibernate.
- R9: With enable clear, the count and divider phase hold. Setting enable again resumes from the held value.
- R10: Writing 0xCCCC to offset 0x0C copies the reload register into the count and clears the divider phase. This takes priority over a tick in the same cycle and raises no timeout. Any other value written there has no effect.
- R11: The count register (offset 0x04) ignores writes. A write to the reload register does not change the count until the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| hibernate | input | 1 | High while the device is in hibernate |
| active | input | 1 | High while the device is in active mode |
| rstReq | output | 1 | One-clock reset request per timeout |
| irq | output | 1 | Sticky debug timeout interrupt |

## Verification
The assertions assume that `addr`, `wdata` and `wrEn` change only between clock edges. They also assume that the count changes only through a tick or a key refresh, since no write path to the count exists. The hold properties assume that `hibernate` is a clean level sampled at the same edges as the bus. The stimulus drives every input on the falling edge, flips `hibernate` and `active` only rarely, and mostly picks the fastest and second prescale settings with small reload values, so timeouts, reloads and wraps all happen within the run.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

  // Byte offsets of the register window
  localparam int unsigned OFF_RELOAD  = 32'h00;
  localparam int unsigned OFF_COUNT   = 32'h04;
  localparam int unsigned OFF_CTRL    = 32'h08;
  localparam int unsigned OFF_REFRESH = 32'h0C;
  localparam int unsigned OFF_IRQCLR  = 32'h10;

  // Control word fields as held in flops
  typedef struct packed {
    logic       periodic;
    logic       enable;
    logic [1:0] prescSel;
    logic       irqSel;
    logic       hibSuspend;
  } ctlWord_t;

  // Strobes from the control side to the counting datapath
  typedef struct packed {
    logic tick;
    logic refresh;
    logic reloadWr;
    logic periodic;
  } dpStrobe_t;

endpackage

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned PRESC_STEP = 4,
  parameter logic [DATA_W-1:0] KEY  = 16'hCCCC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hibernate,
  input  logic              active,
  input  logic              expire,
  input  logic [DATA_W-1:0] reloadVal,
  input  logic [DATA_W-1:0] countVal,
  output dpStrobe_t         strobe,
  output ctlWord_t          ctl,
  output logic [DATA_W-1:0] rdata,
  output logic              rstReq,
  output logic              irq
);

  localparam int unsigned PRESC_W = 3 * PRESC_STEP;
  localparam logic [PRESC_W-1:0] LIM_0 = '0;
  localparam logic [PRESC_W-1:0] LIM_1 = PRESC_W'((1 << PRESC_STEP) - 1);
  localparam logic [PRESC_W-1:0] LIM_2 = PRESC_W'((1 << (2 * PRESC_STEP)) - 1);
  localparam logic [PRESC_W-1:0] LIM_3 = '1;

  ctlWord_t            ctlQ;
  logic [PRESC_W-1:0]  prescCnt;
  logic [PRESC_W-1:0]  prescLimit;
  logic                selReload, selCount, selCtrl, selRefresh, selIrqClr;
  logic                refreshHit, running, atLimit, irqTimeout;

  assign selReload  = (addr == ADDR_W'(OFF_RELOAD));
  assign selCount   = (addr == ADDR_W'(OFF_COUNT));
  assign selCtrl    = (addr == ADDR_W'(OFF_CTRL));
  assign selRefresh = (addr == ADDR_W'(OFF_REFRESH));
  assign selIrqClr  = (addr == ADDR_W'(OFF_IRQCLR));

  assign refreshHit = wrEn && selRefresh && (wdata == KEY);
  assign running    = ctlQ.enable && !(hibernate && ctlQ.hibSuspend);

  always_comb begin
    case (ctlQ.prescSel)
      2'd0:    prescLimit = LIM_0;
      2'd1:    prescLimit = LIM_1;
      2'd2:    prescLimit = LIM_2;
      default: prescLimit = LIM_3;
    endcase
  end

  assign atLimit = (prescCnt >= prescLimit);

  // Control word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ <= '{periodic: 1'b1, enable: 1'b1, prescSel: 2'b10,
                irqSel: 1'b0, hibSuspend: 1'b1};
    end else if (wrEn && selCtrl) begin
      ctlQ <= '{periodic: wdata[6], enable: wdata[5], prescSel: wdata[3:2],
                irqSel: wdata[1], hibSuspend: wdata[0]};
    end
  end

  // Prescaler phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt <= '0;
    end else if (refreshHit) begin
      prescCnt <= '0;
    end else if (running) begin
      prescCnt <= atLimit ? '0 : prescCnt + PRESC_W'(1);
    end
  end

  assign strobe.tick     = running && atLimit;
  assign strobe.refresh  = refreshHit;
  assign strobe.reloadWr = wrEn && selReload;
  assign strobe.periodic = ctlQ.periodic;
  assign ctl             = ctlQ;

  // Timeout action
  assign irqTimeout = expire && ctlQ.irqSel && active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReq <= 1'b0;
      irq    <= 1'b0;
    end else begin
      rstReq <= expire && !irqTimeout;
      if (irqTimeout) begin
        irq <= 1'b1;
      end else if (wrEn && selIrqClr) begin
        irq <= 1'b0;
      end
    end
  end

  // Read mux
  always_comb begin
    rdata = '0;
    if (selReload) begin
      rdata = reloadVal;
    end else if (selCount) begin
      rdata = countVal;
    end else if (selCtrl) begin
      rdata = DATA_W'({1'b1, ctlQ.periodic, ctlQ.enable, 1'b0,
                       ctlQ.prescSel, ctlQ.irqSel, ctlQ.hibSuspend});
    end
  end

endmodule

// File: rtl/wdt_datapath.sv
`timescale 1ns/1ps
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W          = 16,
  parameter logic [DATA_W-1:0] RESET_VAL = 16'h1000,
  parameter logic [DATA_W-1:0] WRAP_VAL  = 16'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] reloadVal,
  output logic [DATA_W-1:0] countVal,
  output logic              expire
);

  logic [DATA_W-1:0] reloadQ;
  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] stepVal;

  always_comb begin
    if (countQ == '0) begin
      stepVal = strobe.periodic ? reloadQ : WRAP_VAL;
    end else begin
      stepVal = countQ - DATA_W'(1);
    end
  end

  assign expire = strobe.tick && !strobe.refresh && (stepVal == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= RESET_VAL;
    end else if (strobe.reloadWr) begin
      reloadQ <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= RESET_VAL;
    end else if (strobe.refresh) begin
      countQ <= reloadQ;
    end else if (strobe.tick) begin
      countQ <= stepVal;
    end
  end

  assign reloadVal = reloadQ;
  assign countVal  = countQ;

endmodule

// File: rtl/wdt_top.sv
`timescale 1ns/1ps
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned PRESC_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              hibernate,
  input  logic              active,
  output logic              rstReq,
  output logic              irq
);

  dpStrobe_t         strobe;
  ctlWord_t          ctl;
  logic              expire;
  logic [DATA_W-1:0] reloadVal;
  logic [DATA_W-1:0] countVal;
  logic              ctlEnable;
  logic              ctlSuspend;

  wdt_ctrl #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .PRESC_STEP(PRESC_STEP)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .wdata    (wdata),
    .hibernate(hibernate),
    .active   (active),
    .expire   (expire),
    .reloadVal(reloadVal),
    .countVal (countVal),
    .strobe   (strobe),
    .ctl      (ctl),
    .rdata    (rdata),
    .rstReq   (rstReq),
    .irq      (irq)
  );

  wdt_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wdata    (wdata),
    .reloadVal(reloadVal),
    .countVal (countVal),
    .expire   (expire)
  );

  assign ctlEnable  = ctl.enable;
  assign ctlSuspend = ctl.hibSuspend;

endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 5,
  parameter logic [DATA_W-1:0] KEY = 16'hCCCC
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              hibernate,
  input logic              rstReq,
  input logic              irq,
  input logic [DATA_W-1:0] countVal,
  input logic              ctlEnable,
  input logic              ctlSuspend
);

  logic pastValid;
  logic keyWrite;
  logic clrWrite;

  assign keyWrite = wrEn && (addr == ADDR_W'(32'h0C)) && (wdata == KEY);
  assign clrWrite = wrEn && (addr == ADDR_W'(32'h10));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R9: disabled timer holds its count
  a_r9_hold_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlEnable && !keyWrite) |=> $stable(countVal));

  // R8: suspended hibernate holds the count
  a_r8_hold_hibernate: assert property (@(posedge clk) disable iff (!rstN)
    (ctlEnable && ctlSuspend && hibernate && !keyWrite) |=> $stable(countVal));

  // R7: interrupt stays until a clear write
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clrWrite) |=> irq);

  // R7: one timeout never raises both outputs
  a_r7_one_action: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> !$rose(irq));

  // R3: a count change away from zero without refresh is a single step down
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && (countVal != $past(countVal)) && ($past(countVal) != '0)
     && !$past(keyWrite)) |-> (countVal == $past(countVal) - DATA_W'(1)));

endmodule

bind wdt_top wdt_checker #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_wdt_checker (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .wdata     (wdata),
  .hibernate (hibernate),
  .rstReq    (rstReq),
  .irq       (irq),
  .countVal  (countVal),
  .ctlEnable (ctlEnable),
  .ctlSuspend(ctlSuspend)
);

// File: tb/tb_wdt_top.sv
`timescale 1ns/1ps
module tb_wdt_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = 5'h04;
  logic [15:0] wdata = '0;
  logic        hibernate = 1'b0;
  logic        active = 1'b1;
  logic [15:0] rdata;
  logic        rstReq;
  logic        irq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .hibernate(hibernate), .active(active),
    .rstReq(rstReq), .irq(irq)
  );

  // Reference model state
  logic [15:0] mLoad, mCount;
  logic        mPer, mEn, mIsel, mSusp, mRst, mIrq;
  logic [1:0]  mSel;
  logic [11:0] mPhase;

  function automatic logic [11:0] divLimit(logic [1:0] s);
    return 12'((32'd1 << (4 * s)) - 1);
  endfunction

  function automatic logic [15:0] modelRead(logic [4:0] a);
    case (a)
      5'h00:   return mLoad;
      5'h04:   return mCount;
      5'h08:   return {8'h00, 1'b1, mPer, mEn, 1'b0, mSel, mIsel, mSusp};
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLoad <= 16'h1000; mCount <= 16'h1000;
      mPer <= 1'b1; mEn <= 1'b1; mSel <= 2'b10; mIsel <= 1'b0; mSusp <= 1'b1;
      mPhase <= '0; mRst <= 1'b0; mIrq <= 1'b0;
    end else begin
      logic        timeout;
      logic [15:0] nxt;
      timeout = 1'b0;
      if (wrEn && addr == 5'h0C && wdata == 16'hCCCC) begin
        mCount <= mLoad;
        mPhase <= '0;
      end else if (mEn && !(hibernate && mSusp)) begin
        if (mPhase >= divLimit(mSel)) begin
          mPhase <= '0;
          if (mCount == 16'h0) nxt = mPer ? mLoad : 16'h1000;
          else                 nxt = mCount - 16'd1;
          mCount <= nxt;
          timeout = (nxt == 16'h0);
        end else begin
          mPhase <= mPhase + 12'd1;
        end
      end
      if (wrEn && addr == 5'h00) mLoad <= wdata;
      if (wrEn && addr == 5'h08) begin
        mPer <= wdata[6]; mEn <= wdata[5]; mSel <= wdata[3:2];
        mIsel <= wdata[1]; mSusp <= wdata[0];
      end
      mRst <= timeout && !(mIsel && active);
      if (timeout && mIsel && active) mIrq <= 1'b1;
      else if (wrEn && addr == 5'h10) mIrq <= 1'b0;
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, just after each edge
  always @(posedge clk) begin
    if (rstN && !done) begin
      #1;
      case (addr)
        5'h00:   check("R11 reload readback", rdata, modelRead(addr));
        5'h04:   check("R4 count readback", rdata, modelRead(addr));
        default: check("R2 control/unmapped readback", rdata, modelRead(addr));
      endcase
      check("R6 rstReq", {15'd0, rstReq}, {15'd0, mRst});
      check("R7 irq", {15'd0, irq}, {15'd0, mIrq});
    end
  end

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0; addr = 5'h04;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(logic [4:0] a, output logic [15:0] v);
    addr = a; #0.2; v = rdata; addr = 5'h04; #0.2;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFail++;
      $display("FAIL R1 watchdog: run did not end, actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [15:0] v, held;
    void'($urandom(32'h1D0F));
    repeat (3) @(negedge clk);
    // R1: reset state
    peek(5'h00, v); check("R1 reload reset", v, 16'h1000);
    peek(5'h04, v); check("R1 count reset", v, 16'h1000);
    peek(5'h08, v); check("R1 control reset", v, 16'h00E9);
    check("R1 rstReq reset", {15'd0, rstReq}, 16'h0);
    check("R1 irq reset", {15'd0, irq}, 16'h0);
    rstN = 1'b1;

    // R3: divide by 16, two ticks in 32 clocks
    wr(5'h08, 16'h0065);
    wr(5'h00, 16'd100);
    wr(5'h0C, 16'hCCCC);
    idle(32);
    peek(5'h04, v); check("R3 /16 count after 32 clocks", v, 16'd98);

    // R10: wrong key ignored, right key reloads
    wr(5'h0C, 16'h1234);
    peek(5'h04, v); check("R10 wrong key ignored", v, 16'd98);
    wr(5'h0C, 16'hCCCC);
    peek(5'h04, v); check("R10 key reload", v, 16'd100);

    // R9: disable freezes
    wr(5'h08, 16'h0045);
    idle(100);
    peek(5'h04, v); check("R9 frozen while disabled", v, 16'd100);

    // R8: suspend in hibernate, then continue with suspend cleared
    wr(5'h08, 16'h0065);
    hibernate = 1'b1;
    idle(100);
    peek(5'h04, v); check("R8 frozen in hibernate", v, 16'd100);
    wr(5'h08, 16'h0064);
    idle(31);
    peek(5'h04, v); check("R8 counts in hibernate without suspend", v, 16'd98);
    hibernate = 1'b0;

    // R5 and R6: free-running wrap and reset pulse
    wr(5'h08, 16'h0021);
    wr(5'h00, 16'd3);
    wr(5'h0C, 16'hCCCC);
    idle(3);
    peek(5'h04, v); check("R5 count at zero", v, 16'h0000);
    check("R6 rstReq after timeout", {15'd0, rstReq}, 16'h1);
    idle(1);
    peek(5'h04, v); check("R5 wrap to 0x1000", v, 16'h1000);
    check("R6 rstReq single clock", {15'd0, rstReq}, 16'h0);

    // R7: interrupt in active mode, clear, fallback when not active
    wr(5'h08, 16'h0063);
    wr(5'h0C, 16'hCCCC);
    idle(3);
    check("R7 irq set", {15'd0, irq}, 16'h1);
    check("R7 no rstReq with irq", {15'd0, rstReq}, 16'h0);
    idle(10);
    check("R7 irq sticky", {15'd0, irq}, 16'h1);
    wr(5'h08, 16'h0043);
    wr(5'h10, 16'h0000);
    check("R7 irq cleared", {15'd0, irq}, 16'h0);
    active = 1'b0;
    wr(5'h08, 16'h0063);
    wr(5'h0C, 16'hCCCC);
    idle(3);
    check("R7 fallback rstReq", {15'd0, rstReq}, 16'h1);
    check("R7 fallback no irq", {15'd0, irq}, 16'h0);
    active = 1'b1;

    // R11: count is read-only, reload write does not touch count
    wr(5'h08, 16'h0043);
    peek(5'h04, held);
    wr(5'h04, 16'h0077);
    peek(5'h04, v); check("R11 count write ignored", v, held);
    wr(5'h00, 16'h0055);
    peek(5'h04, v); check("R11 reload write leaves count", v, held);
    peek(5'h00, v); check("R11 reload written", v, 16'h0055);

    // R2: reserved bits
    wr(5'h08, 16'hFFFF);
    peek(5'h08, v); check("R2 reserved bits", v, 16'h00EF);
    peek(5'h14, v); check("R2 unmapped reads zero", v, 16'h0000);

    // Constrained random phase
    for (int i = 0; i < 20000; i++) begin
      int r;
      @(negedge clk);
      r = int'($urandom % 16);
      wrEn = 1'b0; addr = 5'h04; wdata = 16'($urandom);
      case (r)
        0, 1: begin wrEn = 1'b1; addr = 5'h00; wdata = 16'($urandom % 24); end
        2: begin
          wrEn = 1'b1; addr = 5'h08;
          wdata = {8'($urandom), 1'($urandom), 1'($urandom),
                   1'(($urandom % 8) != 0), 1'($urandom),
                   (($urandom % 8) == 0) ? 2'b01 : 2'b00,
                   1'($urandom), 1'($urandom)};
        end
        3: begin
          wrEn = 1'b1; addr = 5'h0C;
          if (($urandom % 4) != 0) wdata = 16'hCCCC;
        end
        4: begin wrEn = 1'b1; addr = 5'h10; end
        5: begin wrEn = 1'b1; addr = 5'h04; end
        6: if (($urandom % 4) == 0) hibernate = ~hibernate;
        7: if (($urandom % 4) == 0) active = ~active;
        8: addr = 5'($urandom);
        default: ;
      endcase
    end
    @(negedge clk);
    wrEn = 1'b0; addr = 5'h04;
    idle(2);
    done = 1'b1;
    finishRun();
  end

endmodule